// File: doc/BRIEF.md
# General Register File with Width Views

This block holds sixteen 64-bit general registers and lets each access pick a slice of one register: a byte, a 16-bit half-word, a 32-bit word or the full 64-bit value. Two read ports and one write port each carry a register index, a 2-bit size code and a second-byte select. Reads are combinational and return the chosen slice zero-extended to 64 bits. Writes happen on the clock edge. A byte or half-word write leaves every other bit of the register unchanged. A 32-bit write clears the upper 32 bits.

A mode input chooses between a legacy byte map and a long byte map. In legacy mode, the four byte codes at indices 4 to 7 name bits 15:8 of registers 0 to 3, and byte access to indices 8 to 15 is illegal. In long mode, every index names the low byte of its own register. Bits 15:8 of registers 0 to 3 stay reachable in both modes through the second-byte select. A request the map does not allow raises the port's illegal flag. An illegal read returns zero, and an illegal write changes nothing.

Top module: `gpr_view_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all sixteen registers to zero.
- R2: Size code 0 selects a byte, 1 selects bits 15:0, 2 selects bits 31:0 and 3 selects bits 63:0. A read returns the selected slice zero-extended to 64 bits.
- R3: Size code 0 with `*_hi` = 1 and index 0 to 3 selects bits 15:8 of that register. For size codes 1 to 3, `*_hi` is ignored.
- R4: Size code 0 with `*_hi` = 1 and index 4 to 15 is illegal. The port's illegal flag goes high, a read returns zero, and a write leaves every register unchanged.
- R5: With `long_mode` = 1, size code 0 with `*_hi` = 0 selects bits 7:0 of the register named by the index, for any index from 0 to 15.
- R6: With `long_mode` = 0, size code 0 with `*_hi` = 0 and index 0 to 3 selects bits 7:0 of that register. With index 4 to 7, it selects bits 15:8 of register index−4.
- R7: With `long_mode` = 0, size code 0 with `*_hi` = 0 and index 8 to 15 is illegal, with the same effects as in R4.
- R8: A legal byte or 16-bit write replaces only the selected bits and keeps all other bits of the register.
- R9: A legal 32-bit write places the data in bits 31:0 and clears bits 63:32. A 64-bit write replaces the whole register.
- R10: A register changes only at a rising clock edge with `wr_en` high. With `wr_en` low, the contents hold.
- R11: A read of a register in the same cycle as a write to it returns the value from before the write. There is no bypass.
- R12: Both read ports decode index, size, select and mode in the same way, and they work independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| long_mode | input | 1 | 1 = long byte map, 0 = legacy byte map |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_sz | input | 2 | Write size code |
| wr_hi | input | 1 | Write second-byte select |
| wr_data | input | 64 | Write data, taken from the low bits |
| wr_illegal | output | 1 | Write request is illegal |
| ra_idx | input | 4 | Read port A index |
| ra_sz | input | 2 | Read port A size code |
| ra_hi | input | 1 | Read port A second-byte select |
| ra_data | output | 64 | Read port A data, zero-extended |
| ra_illegal | output | 1 | Read port A request is illegal |
| rb_idx | input | 4 | Read port B index |
| rb_sz | input | 2 | Read port B size code |
| rb_hi | input | 1 | Read port B second-byte select |
| rb_data | output | 64 | Read port B data, zero-extended |
| rb_illegal | output | 1 | Read port B request is illegal |

## Verification
The hardest case to reach is aliasing in legacy mode: a byte write through index 4 to 7 must land in bits 15:8 of a different register and must leave that register's other bits alone. To reach it, the stimulus first fills every register with a distinct 64-bit pattern. It then sweeps all combinations of mode, index, size and select. After each write, it reads back all sixteen full registers through both ports and compares them with a bench model. A stray or misplaced byte therefore shows up as a mismatch in a neighbouring register, not only in the one that was addressed. A read of the same view in the cycle of each write covers the rule that reads return the old value.

// File: rtl/gpr_view_file.sv
module gpr_view_file #(
  parameter int NREGS = 16,
  parameter int XLEN  = 64,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            long_mode,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [1:0]      wr_sz,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_illegal,
  input  logic [IW-1:0]   ra_idx,
  input  logic [1:0]      ra_sz,
  input  logic            ra_hi,
  output logic [XLEN-1:0] ra_data,
  output logic            ra_illegal,
  input  logic [IW-1:0]   rb_idx,
  input  logic [1:0]      rb_sz,
  input  logic            rb_hi,
  output logic [XLEN-1:0] rb_data,
  output logic            rb_illegal
);
  typedef struct packed {
    logic          bad;
    logic [IW-1:0] sel;
    logic          hib;
  } view_t;

  logic [XLEN-1:0] regs [NREGS];

  function automatic view_t decode(input logic [IW-1:0] idx, input logic [1:0] sz,
                                   input logic hi, input logic lm);
    view_t v;
    v.bad = 1'b0;
    v.sel = idx;
    v.hib = 1'b0;
    if (sz == 2'd0) begin
      if (hi) begin
        if (idx < IW'(4)) v.hib = 1'b1;
        else              v.bad = 1'b1;
      end else if (!lm && idx >= IW'(4) && idx < IW'(8)) begin
        v.sel = idx - IW'(4);
        v.hib = 1'b1;
      end else if (!lm && idx >= IW'(8)) begin
        v.bad = 1'b1;
      end
    end
    return v;
  endfunction

  function automatic logic [XLEN-1:0] view_rd(input logic [XLEN-1:0] r, input logic [1:0] sz,
                                              input logic hib);
    case (sz)
      2'd0:    return XLEN'(hib ? r[15:8] : r[7:0]);
      2'd1:    return XLEN'(r[15:0]);
      2'd2:    return XLEN'(r[31:0]);
      default: return r;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] r, input logic [XLEN-1:0] d,
                                            input logic [1:0] sz, input logic hib);
    logic [XLEN-1:0] n;
    n = r;
    case (sz)
      2'd0: if (hib) n[15:8] = d[7:0];
            else     n[7:0]  = d[7:0];
      2'd1: n[15:0] = d[15:0];
      2'd2: n = XLEN'(d[31:0]);
      default: n = d;
    endcase
    return n;
  endfunction

  view_t va, vb, vw;
  assign va = decode(ra_idx, ra_sz, ra_hi, long_mode);
  assign vb = decode(rb_idx, rb_sz, rb_hi, long_mode);
  assign vw = decode(wr_idx, wr_sz, wr_hi, long_mode);

  assign ra_illegal = va.bad;
  assign rb_illegal = vb.bad;
  assign wr_illegal = vw.bad;
  assign ra_data = va.bad ? '0 : view_rd(regs[va.sel], ra_sz, va.hib);
  assign rb_data = vb.bad ? '0 : view_rd(regs[vb.sel], rb_sz, vb.hib);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en && !vw.bad) begin
      regs[vw.sel] <= merge(regs[vw.sel], wr_data, wr_sz, vw.hib);
    end
  end
endmodule

// File: rtl/gpr_view_file_chk.sv
module gpr_view_file_chk #(
  parameter int XLEN = 64,
  parameter int IW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            long_mode,
  input logic            wr_en,
  input logic [IW-1:0]   wr_idx,
  input logic [1:0]      wr_sz,
  input logic [XLEN-1:0] wr_data,
  input logic            wr_illegal,
  input logic [IW-1:0]   ra_idx,
  input logic [1:0]      ra_sz,
  input logic            ra_hi,
  input logic [XLEN-1:0] ra_data,
  input logic            ra_illegal
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ra_data == '0); // R1

  AST_BYTE_ZERO_EXTENDED: assert property (@(posedge clk) disable iff (rst)
    (ra_sz == 2'd0) |-> ra_data[XLEN-1:8] == '0); // R2

  AST_HIGH_BYTE_UPPER_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (ra_sz == 2'd0 && ra_hi && ra_idx >= IW'(4)) |-> ra_illegal); // R4

  AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ra_illegal |-> ra_data == '0); // R4

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(ra_idx) && $stable(ra_sz) && $stable(ra_hi)
     && $stable(long_mode)) |-> $stable(ra_data)); // R10

  AST_WORD_WRITE_CLEARS_TOP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(wr_illegal) && $past(wr_sz) == 2'd2
     && ra_sz == 2'd3 && ra_idx == $past(wr_idx))
    |-> ra_data == XLEN'($past(wr_data[31:0]))); // R9

  AST_FULL_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(wr_illegal) && $past(wr_sz) == 2'd3
     && ra_sz == 2'd3 && ra_idx == $past(wr_idx))
    |-> ra_data == $past(wr_data)); // R9
endmodule

bind gpr_view_file gpr_view_file_chk #(.XLEN(XLEN), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .long_mode(long_mode), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_sz(wr_sz), .wr_data(wr_data), .wr_illegal(wr_illegal), .ra_idx(ra_idx),
  .ra_sz(ra_sz), .ra_hi(ra_hi), .ra_data(ra_data), .ra_illegal(ra_illegal)
);

// File: tb/gpr_view_file_tb.sv
`timescale 1ns/100ps
module gpr_view_file_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        long_mode = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [1:0]  wr_sz = '0;
  logic        wr_hi = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wr_illegal;
  logic [3:0]  ra_idx = '0;
  logic [1:0]  ra_sz = '0;
  logic        ra_hi = 1'b0;
  logic [63:0] ra_data;
  logic        ra_illegal;
  logic [3:0]  rb_idx = '0;
  logic [1:0]  rb_sz = '0;
  logic        rb_hi = 1'b0;
  logic [63:0] rb_data;
  logic        rb_illegal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [63:0] model [16];

  always #10 clk = ~clk;

  gpr_view_file u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit locate(input bit lm, input int idx, input int sz, input bit hi,
                                output int preg, output int lsb);
    preg = idx;
    lsb = 0;
    if (sz != 0) return 1'b1;
    if (hi) begin
      lsb = 8;
      return idx < 4;
    end
    if (lm || idx < 4) return 1'b1;
    if (idx < 8) begin
      preg = idx - 4;
      lsb = 8;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [63:0] width_mask(input int sz);
    return (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
  endfunction

  function automatic logic [63:0] expect_view(input bit lm, input int idx, input int sz, input bit hi);
    int p, l;
    if (!locate(lm, idx, sz, hi, p, l)) return '0;
    return (model[p] >> l) & width_mask(sz);
  endfunction

  task automatic check_all_regs(input string req);
    for (int k = 0; k < 8; k++) begin
      ra_idx = 4'(k);     ra_sz = 2'd3; ra_hi = 1'b0;
      rb_idx = 4'(k + 8); rb_sz = 2'd3; rb_hi = 1'b1;
      #1;
      chk(req, ra_data, model[k]);
      chk(req, rb_data, model[k + 8]);
    end
  endtask

  task automatic do_write(input bit lm, input int idx, input int sz, input bit hi, input logic [63:0] v);
    int p, l;
    bit ok;
    logic [63:0] m;
    ok = locate(lm, idx, sz, hi, p, l);
    @(negedge clk);
    long_mode = lm; wr_en = 1'b1; wr_idx = 4'(idx); wr_sz = 2'(sz); wr_hi = hi; wr_data = v;
    ra_idx = 4'(idx); ra_sz = 2'(sz); ra_hi = hi;
    rb_idx = 4'(idx); rb_sz = 2'(sz); rb_hi = hi;
    #1;
    chk(ok ? "R3/R5/R6 wr_illegal" : "R4/R7 wr_illegal", 64'(wr_illegal), 64'(!ok));
    chk("R11 same-cycle read returns old", ra_data, expect_view(lm, idx, sz, hi));
    chk(ok ? "R2 ra_illegal" : "R4/R7 ra_illegal", 64'(ra_illegal), 64'(!ok));
    @(posedge clk);
    if (ok) begin
      if (sz == 2) model[p] = {32'h0, v[31:0]};
      else begin
        m = width_mask(sz) << l;
        model[p] = (model[p] & ~m) | ((v << l) & m);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R12 port B view after write", rb_data, expect_view(lm, idx, sz, hi));
    chk("R8/R9 port A view after write", ra_data, expect_view(lm, idx, sz, hi));
    check_all_regs(ok ? "R8/R9 registers after legal write" : "R4/R7 no change after illegal write");
  endtask

  initial begin
    for (int k = 0; k < 16; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check_all_regs("R1 reset state");

    for (int k = 0; k < 16; k++)
      do_write(1'b1, k, 3, 1'b0, 64'hF0E1_D2C3_B4A5_9687 ^ (64'(k) * 64'h1111_0101_2222_0303));

    begin
      int n = 0;
      for (int lm = 0; lm < 2; lm++)
        for (int idx = 0; idx < 16; idx++)
          for (int sz = 0; sz < 4; sz++)
            for (int hi = 0; hi < 2; hi++) begin
              n++;
              do_write(lm[0], idx, sz, hi[0], 64'h0123_4567_89AB_CDEF ^ (64'(n) * 64'h9E37_79B9_7F4A_7C15));
            end
    end

    // R3 R5 R6 R7: read-only sweep of every view in both modes
    for (int lm = 0; lm < 2; lm++)
      for (int idx = 0; idx < 16; idx++)
        for (int sz = 0; sz < 4; sz++)
          for (int hi = 0; hi < 2; hi++) begin
            @(negedge clk);
            long_mode = lm[0];
            ra_idx = 4'(idx); ra_sz = 2'(sz); ra_hi = hi[0];
            rb_idx = 4'(15 - idx); rb_sz = 2'(3 - sz); rb_hi = ~hi[0];
            #1;
            chk("R3/R5/R6 port A view", ra_data, expect_view(lm[0], idx, sz, hi[0]));
            chk("R12 port B view", rb_data, expect_view(lm[0], 15 - idx, 3 - sz, ~hi[0]));
          end

    // R10: write fields driven with enable low
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 4'd5; wr_sz = 2'd3; wr_data = '1;
    @(posedge clk);
    @(negedge clk);
    check_all_regs("R10 no write with enable low");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 16; k++) model[k] = '0;
    #1;
    check_all_regs("R1 reset after activity");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule